// File: doc/BRIEF.md
# ATA PIO Strobe Timing Engine

This block paces programmed-I/O transfers on one ATA cable that carries a master and a slave drive. A host-side requester asks for a read or write cycle, aimed at either a task-file register or the data port. The engine then drives the active-low read or write strobe. It waits a programmed number of clocks before it first looks at the IORDY ready line, and holds the strobe while the drive is not ready. After the strobe it enforces a programmed minimum recovery gap before the next strobe may begin.

Timing comes from 2-bit encoded fields. By default one sample-point and recovery pair serves both drives. A slave-timing enable gives drive 1 its own pair. The active drive is tracked by snooping bit 4 of every write to the drive/head register. Each drive has an IORDY-enable bit; when it is clear, ready is forced true. Each drive also has a DMA-only fast-timing bit, which makes data-port PIO cycles to that drive fall back to the slowest timing. A decode-enable input gates acceptance of all cycles.

Top module: `ata_pio_timer`

## Requirements
- R1: While reset is asserted and after it, both strobes are high (1), done_o is 0 and busy_o is 0 until a cycle is accepted.
- R2: An accepted request drives dior_no low for a read (req_wr_i=0) or diow_no low for a write (req_wr_i=1), starting on the clock after acceptance. With ready true, the strobe stays low for 5, 4, 3 or 2 clocks for sample-point codes 00, 01, 10 and 11.
- R3: After the last IORDY sample, the strobes stay high for at least 4, 3, 2 or 1 clocks for recovery codes 00, 01, 10 and 11 before the next strobe asserts.
- R4: When the selected drive's IORDY-enable bit is 1 and iordy_i is 0 at the sample point, the strobe stays low and iordy_i is re-sampled every clock. The strobe rises on the clock after iordy_i is seen at 1.
- R5: When the drive's IORDY-enable bit is 0, iordy_i is ignored and the cycle ends at the first sample point.
- R6: The selected drive is bit 4 of the data written to the drive/head register (dh_wr_i pulse with dh_bit4_i). The value takes effect for cycles that start after the write edge.
- R7: When slave_tim_en_i is 1 and drive 1 is selected, the slave field pair is used. Otherwise the master pair is used for both drives.
- R8: When the selected drive's DMA-only bit is 1, data-port cycles (req_data_i=1) use codes 00/00 whatever is programmed. Register cycles to that drive use the programmed fields.
- R9: While dec_en_i is 0, no request is accepted.
- R10: A request that arrives during recovery is held, with busy_o staying high. Its strobe asserts on the clock at which recovery expires.
- R11: A request that arrives while a strobe is active, or while a request is already held, is ignored.
- R12: done_o pulses high for one clock, in the first clock that the strobe is high again. The two strobes are never low together, and busy_o is high whenever a strobe is low or recovery runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_en_i | input | 1 | Cycle acceptance enable |
| slave_tim_en_i | input | 1 | Drive 1 uses the slave field pair |
| m_isp_i | input | 2 | Master/shared sample-point code |
| m_rtc_i | input | 2 | Master/shared recovery code |
| s_isp_i | input | 2 | Slave sample-point code |
| s_rtc_i | input | 2 | Slave recovery code |
| iordy_en_i | input | 2 | Per-drive IORDY sampling enable |
| dma_only_i | input | 2 | Per-drive DMA-only fast-timing bit |
| dh_wr_i | input | 1 | Write to drive/head register seen |
| dh_bit4_i | input | 1 | Bit 4 of that write's data |
| req_i | input | 1 | Cycle request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_data_i | input | 1 | 1 = data port, 0 = task-file register |
| iordy_i | input | 1 | Drive ready line (synchronised) |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| done_o | output | 1 | One-clock cycle-complete pulse |
| busy_o | output | 1 | Strobe or recovery in progress |

## Verification
Two things can meet at one clock edge: the expiry of the recovery count and the arrival, or earlier capture, of the next request. The bench provokes this by issuing a second request on the clock where done_o is seen, at both the longest and the shortest recovery code. A drive/head snoop write is also made in the same cycle as a request. A behavioural model predicts every output on each clock, so a strobe that starts one clock early or late, a held request that is lost, or a drive select that is applied too soon is reported.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned CNT_W  = 3;
  localparam int unsigned N_DRV  = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_STRB, PH_RECV} phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] isp;
    logic [CNT_W-1:0] rtc;
    logic             ie;
  } tim_t;

  function automatic logic [CNT_W-1:0] code2clk(input logic [CODE_W-1:0] code,
                                                 input int unsigned base);
    return CNT_W'(base) - CNT_W'(code);
  endfunction
endpackage

// File: rtl/ata_tim_sel.sv
module ata_tim_sel
  import ata_pio_pkg::*;
#(
  parameter int unsigned ISP_BASE = 5,
  parameter int unsigned RTC_BASE = 4
) (
  input  logic              dsel_i,
  input  logic              slave_tim_en_i,
  input  logic [CODE_W-1:0] m_isp_i,
  input  logic [CODE_W-1:0] m_rtc_i,
  input  logic [CODE_W-1:0] s_isp_i,
  input  logic [CODE_W-1:0] s_rtc_i,
  input  logic [N_DRV-1:0]  iordy_en_i,
  input  logic [N_DRV-1:0]  dma_only_i,
  input  logic              data_i,
  output tim_t              tim_o
);
  logic              use_slv, compat;
  logic [CODE_W-1:0] isp_c, rtc_c;

  assign use_slv = dsel_i & slave_tim_en_i;
  assign compat  = data_i & dma_only_i[dsel_i];

  always_comb begin
    isp_c = use_slv ? s_isp_i : m_isp_i;
    rtc_c = use_slv ? s_rtc_i : m_rtc_i;
    if (compat) begin
      isp_c = '0;
      rtc_c = '0;
    end
  end

  assign tim_o.isp = code2clk(isp_c, ISP_BASE);
  assign tim_o.rtc = code2clk(rtc_c, RTC_BASE);
  assign tim_o.ie  = iordy_en_i[dsel_i];
endmodule

// File: rtl/ata_strobe_seq.sv
module ata_strobe_seq
  import ata_pio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic req_wr_i,
  input  logic req_data_i,
  input  logic iordy_i,
  input  tim_t tim_i,
  output logic sel_data_o,
  output logic dior_no,
  output logic diow_no,
  output logic done_o,
  output logic busy_o
);
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q, rtc_q;
  logic             ie_q, pend_q, pend_wr_q, pend_data_q;
  logic             last, ready, launch, launch_wr;

  assign last       = (cnt_q <= CNT_W'(1));
  assign ready      = ~ie_q | iordy_i;
  assign launch     = (ph_q == PH_IDLE && acc_i) ||
                      (ph_q == PH_RECV && last && (pend_q || acc_i));
  assign launch_wr  = (ph_q == PH_RECV && pend_q) ? pend_wr_q : req_wr_i;
  assign sel_data_o = (ph_q == PH_RECV && pend_q) ? pend_data_q : req_data_i;
  assign busy_o     = (ph_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      rtc_q       <= '0;
      ie_q        <= 1'b0;
      pend_q      <= 1'b0;
      pend_wr_q   <= 1'b0;
      pend_data_q <= 1'b0;
      dior_no     <= 1'b1;
      diow_no     <= 1'b1;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (launch) begin
        ph_q    <= PH_STRB;
        cnt_q   <= tim_i.isp;
        rtc_q   <= tim_i.rtc;
        ie_q    <= tim_i.ie;
        pend_q  <= 1'b0;
        dior_no <= launch_wr;
        diow_no <= ~launch_wr;
      end else begin
        unique case (ph_q)
          PH_STRB: begin
            if (!last) cnt_q <= cnt_q - 1'b1;
            else if (ready) begin
              ph_q    <= PH_RECV;
              cnt_q   <= rtc_q;
              dior_no <= 1'b1;
              diow_no <= 1'b1;
              done_o  <= 1'b1;
            end
          end
          PH_RECV: begin
            if (!last) begin
              cnt_q <= cnt_q - 1'b1;
              if (acc_i && !pend_q) begin
                pend_q      <= 1'b1;
                pend_wr_q   <= req_wr_i;
                pend_data_q <= req_data_i;
              end
            end else begin
              ph_q <= PH_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_pio_pkg::*;
#(
  parameter int unsigned ISP_BASE = 5,
  parameter int unsigned RTC_BASE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_en_i,
  input  logic              slave_tim_en_i,
  input  logic [CODE_W-1:0] m_isp_i,
  input  logic [CODE_W-1:0] m_rtc_i,
  input  logic [CODE_W-1:0] s_isp_i,
  input  logic [CODE_W-1:0] s_rtc_i,
  input  logic [N_DRV-1:0]  iordy_en_i,
  input  logic [N_DRV-1:0]  dma_only_i,
  input  logic              dh_wr_i,
  input  logic              dh_bit4_i,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic              req_data_i,
  input  logic              iordy_i,
  output logic              dior_no,
  output logic              diow_no,
  output logic              done_o,
  output logic              busy_o
);
  logic dsel_q, sel_data;
  tim_t tim;

  // drive select snooped from drive/head register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dsel_q <= 1'b0;
    else if (dh_wr_i) dsel_q <= dh_bit4_i;
  end

  ata_tim_sel #(.ISP_BASE(ISP_BASE), .RTC_BASE(RTC_BASE)) i_sel (
    .dsel_i         (dsel_q),
    .slave_tim_en_i (slave_tim_en_i),
    .m_isp_i        (m_isp_i),
    .m_rtc_i        (m_rtc_i),
    .s_isp_i        (s_isp_i),
    .s_rtc_i        (s_rtc_i),
    .iordy_en_i     (iordy_en_i),
    .dma_only_i     (dma_only_i),
    .data_i         (sel_data),
    .tim_o          (tim)
  );

  ata_strobe_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (req_i & dec_en_i),
    .req_wr_i   (req_wr_i),
    .req_data_i (req_data_i),
    .iordy_i    (iordy_i),
    .tim_i      (tim),
    .sel_data_o (sel_data),
    .dior_no    (dior_no),
    .diow_no    (diow_no),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );
endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dec_en_i,
  input logic dior_no,
  input logic diow_no,
  input logic done_o,
  input logic busy_o
);
  assert_no_overlap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dior_no || diow_no);

  assert_done_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dior_no && diow_no && (!$past(dior_no) || !$past(diow_no))));

  assert_strobe_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_no || !diow_no) |-> busy_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (dior_no && diow_no && !done_o));

  assert_no_decode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !dec_en_i) |=> !busy_o);
endmodule

bind ata_pio_timer ata_pio_timer_chk i_chk (.*);

// File: tb/test_ata_pio_timer.sv
`timescale 1ns/1ps
module test_ata_pio_timer;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic dec_en_i = 1'b1, slave_tim_en_i = 1'b0;
  logic [1:0] m_isp_i = '0, m_rtc_i = '0, s_isp_i = '0, s_rtc_i = '0;
  logic [1:0] iordy_en_i = '0, dma_only_i = '0;
  logic dh_wr_i = 0, dh_bit4_i = 0, req_i = 0, req_wr_i = 0, req_data_i = 0, iordy_i = 1;
  logic dior_no, diow_no, done_o, busy_o;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2.5 clk_i = ~clk_i;

  ata_pio_timer i_ata_pio_timer (.*);

  // behavioural reference
  int ph, cnt, m_rtc, pend_q;
  bit m_ie, m_rd, m_wr, m_done, dsel, pw, pd;

  task automatic m_start(input bit wr, input bit data);
    int ic, rc;
    bit slv;
    slv = dsel && slave_tim_en_i;
    ic = slv ? s_isp_i : m_isp_i;
    rc = slv ? s_rtc_i : m_rtc_i;
    if (data && dma_only_i[dsel]) begin ic = 0; rc = 0; end
    cnt = 5 - ic; m_rtc = 4 - rc; m_ie = iordy_en_i[dsel];
    m_rd = wr; m_wr = !wr; ph = 1;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph = 0; cnt = 0; pend_q = 0; m_rd = 1; m_wr = 1; m_done = 0; dsel = 0;
    end else begin
      bit acc;
      acc = req_i && dec_en_i;
      m_done = 0;
      if (ph == 0) begin
        if (acc) m_start(req_wr_i, req_data_i);
      end else if (ph == 1) begin
        if (cnt > 1) cnt--;
        else if (!m_ie || iordy_i) begin
          ph = 2; cnt = m_rtc; m_rd = 1; m_wr = 1; m_done = 1;
        end
      end else begin
        if (cnt > 1) begin
          cnt--;
          if (acc && pend_q == 0) begin pend_q = 1; pw = req_wr_i; pd = req_data_i; end
        end else if (pend_q != 0) begin
          pend_q = 0; m_start(pw, pd);
        end else if (acc) m_start(req_wr_i, req_data_i);
        else ph = 0;
      end
      if (dh_wr_i) dsel = dh_bit4_i;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk_i) begin
    cycles++;
    if (!finished) begin
      chk(cur_req, "dior_no", dior_no, m_rd);
      chk(cur_req, "diow_no", diow_no, m_wr);
      chk(cur_req, "done_o", done_o, m_done);
      chk(cur_req, "busy_o", busy_o, ph != 0);
    end
    if (cycles > 100000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_req(input bit wr, input bit data);
    req_i = 1; req_wr_i = wr; req_data_i = data;
    tick(1);
    req_i = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((busy_o || ph != 0) && guard < 200) begin tick(1); guard++; end
    tick(1);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done_o && guard < 200) begin tick(1); guard++; end
  endtask

  initial begin
    tick(3);
    chk("R1", "reset dior_no", dior_no, 1);
    chk("R1", "reset diow_no", diow_no, 1);
    chk("R1", "reset busy_o", busy_o, 0);
    rst_ni = 1;
    tick(2);
    chk("R1", "post-reset done_o", done_o, 0);

    cur_req = "R2";
    for (int c = 0; c < 4; c++) begin
      m_isp_i = 2'(c);
      pulse_req(c[0], 0);
      wait_idle();
    end

    cur_req = "R3";
    m_isp_i = 2'b11;
    for (int c = 0; c < 4; c++) begin
      m_rtc_i = 2'(c);
      pulse_req(1, 1);
      wait_done();
      cur_req = "R10";
      pulse_req(0, 1);
      wait_idle();
      cur_req = "R3";
    end

    cur_req = "R4";
    m_isp_i = 2'b10; m_rtc_i = 2'b00;
    iordy_en_i = 2'b01; iordy_i = 0;
    pulse_req(0, 1);
    tick(7);
    iordy_i = 1;
    wait_idle();

    cur_req = "R5";
    iordy_en_i = 2'b00; iordy_i = 0;
    pulse_req(1, 0);
    wait_idle();
    iordy_i = 1;

    cur_req = "R6";
    s_isp_i = 2'b11; s_rtc_i = 2'b11; m_isp_i = 2'b00; m_rtc_i = 2'b01;
    slave_tim_en_i = 1;
    dh_wr_i = 1; dh_bit4_i = 1; req_i = 1; req_wr_i = 0; req_data_i = 0;
    tick(1);
    dh_wr_i = 0; req_i = 0;
    wait_idle();

    cur_req = "R7";
    pulse_req(1, 0);
    wait_idle();
    slave_tim_en_i = 0;
    pulse_req(0, 0);
    wait_idle();
    iordy_en_i = 2'b10; iordy_i = 0;
    pulse_req(0, 0);
    tick(9);
    iordy_i = 1;
    wait_idle();
    iordy_en_i = 2'b00;

    cur_req = "R8";
    dh_wr_i = 1; dh_bit4_i = 0; tick(1); dh_wr_i = 0;
    m_isp_i = 2'b11; m_rtc_i = 2'b11; dma_only_i = 2'b01;
    pulse_req(0, 1);
    wait_idle();
    pulse_req(0, 0);
    wait_idle();
    dma_only_i = 2'b00;

    cur_req = "R9";
    dec_en_i = 0;
    pulse_req(1, 1);
    tick(4);
    chk("R9", "busy_o with decode off", busy_o, 0);
    chk("R9", "diow_no with decode off", diow_no, 1);
    dec_en_i = 1;

    cur_req = "R11";
    m_isp_i = 2'b00; m_rtc_i = 2'b00;
    pulse_req(0, 0);
    tick(1);
    pulse_req(1, 0);
    wait_done();
    tick(1);
    pulse_req(1, 1);
    pulse_req(0, 1);
    wait_idle();
    chk("R11", "busy_o after ignored request", busy_o, 0);

    cur_req = "R12";
    m_isp_i = 2'b11; m_rtc_i = 2'b11;
    req_i = 1; req_wr_i = 1; req_data_i = 1;
    tick(12);
    req_i = 0;
    wait_idle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule